// File: doc/BRIEF.md
# Tagged Receive Packet Byte FIFO

This block buffers received bytes for one HDLC channel between an upstream deframer and a processor. Every stored byte carries a 3-bit packet status tag. The tag marks the byte as the start of a packet, a middle byte, or one of several kinds of packet end. The deframer presents one byte per write strobe, together with its tag and a bit-order select. When the select is set, the byte is mirrored before it is stored.

The processor drains the FIFO through two byte-wide registers. The status register previews the entry at the head of the FIFO, showing its tag and a valid flag. A read of the data register returns that head byte and pops it. Software can therefore learn where a packet ends, and whether it ended cleanly, before it takes the byte. Each instance decodes its own pair of addresses from its channel number, so up to eight instances can share one read bus.

Top module: `hrf_rx_tag_fifo`

## Requirements
- R1: After reset the FIFO is empty. The status register reads 0x00, `rd_data_o` is 0x00 and `overflow_o` is 0.
- R2: The status register layout is as follows. Bit 0 is the valid flag, which is 1 when the FIFO holds data. Bits 3:1 hold the head entry's tag. Bits 7:4 always read as 0. Tag codes:
  - 3'b001: first byte of a packet.
  - 3'b000: middle byte.
  - 3'b100: last byte of a good packet.
  - 3'b101: last byte of a packet with a bad checksum.
  - 3'b110: last byte of a packet that is not a whole number of bytes.
  - 3'b111: last byte of an aborted packet.
  - 3'b010 and 3'b011: reserved.
- R3: The status register always describes the entry that the next data read will return. Reading the status register changes no state.
- R4: A data register read returns the head byte and pops it. Bytes leave in the order they were written, and the status then shows the following entry.
- R5: A data register read on an empty FIFO returns 0x00. It leaves the FIFO contents and the status unchanged.
- R6: When `wr_msb_first_i`=0, the byte is stored as given, with bit 0 being the first bit received. When `wr_msb_first_i`=1, the byte is stored bit-reversed, so that bit 7 is the first bit received.
- R7: The status register is at 0x151C + 0x20*(CHAN-1) and the data register is at the next address, for CHAN from 1 to 8. A read of any other address returns 0x00 and pops nothing.
- R8: The FIFO holds DEPTH entries (default 256). A write to a full FIFO with no pop in the same cycle is dropped and sets `overflow_o`. `overflow_o` stays set until reset.
- R9: A write and a data read may occur in the same cycle. On a non-empty FIFO both take effect, which includes a full FIFO, and occupancy stays the same. On an empty FIFO the read returns 0x00 and the write is stored.
- R10: Read data appears on `rd_data_o` in the cycle after the clock edge that samples `rd_en_i`. `rd_data_o` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe from the deframer |
| wr_byte_i | input | 8 | Received byte, bit 0 first on the line |
| wr_tag_i | input | 3 | Packet status tag for this byte |
| wr_msb_first_i | input | 1 | Store the byte bit-reversed |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 16 | Register read address |
| rd_data_o | output | 8 | Registered read data |
| overflow_o | output | 1 | Sticky flag for a dropped write |

## Verification
A wrong pointer or count shows up at the ports at the next status read. A wrong count can clear the valid flag too early, or show a stale tag, and each data read then returns bytes out of order. A faulty full or empty decision stays hidden until the FIFO reaches its limits. For that reason the bench fills all DEPTH entries and drains them again, checking each byte in turn, and it checks the dropped write and the simultaneous write and read at both the full and the empty ends. A bit-order fault or a tag fault shows up on the first read of the affected entry.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

    localparam int BYTE_W = 8;
    localparam int TAG_W  = 3;

    typedef enum logic [TAG_W-1:0] {
        TAG_MID     = 3'b000,
        TAG_SOP     = 3'b001,
        TAG_RSV2    = 3'b010,
        TAG_RSV3    = 3'b011,
        TAG_EOP_OK  = 3'b100,
        TAG_EOP_FCS = 3'b101,
        TAG_EOP_ODD = 3'b110,
        TAG_EOP_ABT = 3'b111
    } pkt_tag_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        pkt_tag_e          tag;
    } entry_t;

endpackage

// File: rtl/hrf_bit_order.sv
module hrf_bit_order #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    input  logic         rev,
    output logic [W-1:0] dout
);
    logic [W-1:0] mirrored;

    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign mirrored[i] = din[W-1-i];
    end

    assign dout = rev ? mirrored : din;
endmodule

// File: rtl/hrf_store.sv
module hrf_store
    import hrf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  entry_t        wentry,
    input  logic [AW-1:0] raddr,
    output entry_t        rentry
);
    entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wentry;
        end
    end

    assign rentry = mem[raddr];
endmodule

// File: rtl/hrf_ctrl.sv
module hrf_ctrl #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          push_ok,
    output logic          empty,
    output logic          overflow
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          ovf;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic  full, pop_ok;

    always_comb begin
        st_d    = st_q;
        full    = (st_q.count == FULL_CNT);
        empty   = (st_q.count == '0);
        pop_ok  = pop_req && !empty;
        push_ok = push_req && (!full || pop_ok);

        if (push_req && !push_ok) begin
            st_d.ovf = 1'b1;
        end
        if (push_ok) begin
            st_d.wr_ptr = (st_q.wr_ptr == LAST_PTR) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST_PTR) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr   = st_q.wr_ptr;
    assign rd_ptr   = st_q.rd_ptr;
    assign overflow = st_q.ovf;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= FULL_CNT);                                    // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);                                     // R8
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push_req) |=> ($stable(rd_ptr) && empty)); // R5
    AST_SIMUL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !empty) |=> $stable(st_q.count));   // R9
endmodule

// File: rtl/hrf_rx_tag_fifo.sv
module hrf_rx_tag_fifo
    import hrf_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int CHAN      = 1,
    parameter int ADDR_W    = 16,
    parameter int CH_BASE   = 'h151C,
    parameter int CH_STRIDE = 'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_byte_i,
    input  logic [2:0]        wr_tag_i,
    input  logic              wr_msb_first_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              overflow_o
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(CH_BASE + CH_STRIDE * (CHAN - 1));
    localparam logic [ADDR_W-1:0] DATA_ADDR = STAT_ADDR + 1'b1;

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
    } rd_t;

    rd_t            rd_q, rd_d;
    logic           sel_stat, sel_data, empty, push_ok;
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [7:0]     ordered;
    entry_t         head, wentry;
    logic [7:0]     status_byte;

    assign sel_stat = rd_en_i && (rd_addr_i == STAT_ADDR);
    assign sel_data = rd_en_i && (rd_addr_i == DATA_ADDR);

    hrf_bit_order #(.W(BYTE_W)) u_order (
        .din  (wr_byte_i),
        .rev  (wr_msb_first_i),
        .dout (ordered)
    );

    assign wentry = '{data: ordered, tag: pkt_tag_e'(wr_tag_i)};

    hrf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_en_i),
        .pop_req  (sel_data),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .push_ok  (push_ok),
        .empty    (empty),
        .overflow (overflow_o)
    );

    hrf_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .we     (push_ok),
        .waddr  (wr_ptr),
        .wentry (wentry),
        .raddr  (rd_ptr),
        .rentry (head)
    );

    always_comb begin
        status_byte = 8'h00;
        if (!empty) begin
            status_byte = {4'b0000, head.tag, 1'b1};
        end
        rd_d = rd_q;
        if (sel_stat) begin
            rd_d.rdata = status_byte;
        end else if (sel_data) begin
            rd_d.rdata = empty ? 8'h00 : head.data;
        end else if (rd_en_i) begin
            rd_d.rdata = 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data_o = rd_q.rdata;

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sel_stat |=> (rd_data_o[7:4] == 4'h0));                     // R2
    AST_EMPTY_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_data && empty) |=> (rd_data_o == 8'h00));              // R5
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !sel_stat && !sel_data) |=> (rd_data_o == 8'h00)); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));                           // R10
endmodule

// File: tb/hrf_rx_tag_fifo_test.sv
`timescale 1ns/1ps
module hrf_rx_tag_fifo_test;
    localparam int DEPTH = 256;
    localparam int CHAN  = 3;
    localparam logic [15:0] A_STAT = 16'h151C + 16'h20 * (CHAN - 1);
    localparam logic [15:0] A_DATA = A_STAT + 16'h1;

    // {msb_first, tag[2:0], byte[7:0]}
    localparam logic [11:0] VEC [8] = '{
        {1'b0, 3'b001, 8'h7E}, {1'b0, 3'b000, 8'h01},
        {1'b1, 3'b000, 8'h01}, {1'b1, 3'b000, 8'hC5},
        {1'b0, 3'b100, 8'hA5}, {1'b0, 3'b101, 8'h3C},
        {1'b1, 3'b110, 8'h80}, {1'b0, 3'b111, 8'hFF}
    };

    logic        clk = 0, rst_n = 0;
    logic        wr_en = 0, wr_msb = 0, rd_en = 0;
    logic [7:0]  wr_byte = 0;
    logic [2:0]  wr_tag = 0;
    logic [15:0] rd_addr = 0;
    logic [7:0]  rd_data;
    logic        ovf;
    int          n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    hrf_rx_tag_fifo #(.DEPTH(DEPTH), .CHAN(CHAN)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_byte_i(wr_byte),
        .wr_tag_i(wr_tag), .wr_msb_first_i(wr_msb), .rd_en_i(rd_en),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .overflow_o(ovf)
    );

    function automatic logic [7:0] mirror(input logic [7:0] b);
        for (int i = 0; i < 8; i++) mirror[i] = b[7-i];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [7:0] b, input logic [2:0] t,
                       input logic m, input logic re, input logic [15:0] a);
        wr_en = we; wr_byte = b; wr_tag = t; wr_msb = m; rd_en = re; rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic rd_stat(output logic [7:0] v);
        cyc(0, 0, 0, 0, 1, A_STAT); v = rd_data;
    endtask

    task automatic rd_dat(output logic [7:0] v);
        cyc(0, 0, 0, 0, 1, A_DATA); v = rd_data;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v, exp_b;
        do_reset();
        // R1 reset state
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 overflow", {7'b0, ovf}, 8'h00);
        rd_stat(v); chk("R1 status", v, 8'h00);

        // Table walk: write all vectors, then preview and pop each one
        for (int i = 0; i < 8; i++) cyc(1, VEC[i][7:0], VEC[i][10:8], VEC[i][11], 0, 0);
        for (int i = 0; i < 8; i++) begin
            exp_b = VEC[i][11] ? mirror(VEC[i][7:0]) : VEC[i][7:0];
            rd_stat(v); chk("R2 R3 status", v, {4'b0, VEC[i][10:8], 1'b1});
            rd_stat(v); chk("R3 status repeat", v, {4'b0, VEC[i][10:8], 1'b1});
            rd_dat(v);  chk("R4 R6 data", v, exp_b);
        end
        rd_stat(v); chk("R4 drained status", v, 8'h00);

        // R5 empty data read
        rd_dat(v); chk("R5 empty data", v, 8'h00);
        cyc(1, 8'h5A, 3'b001, 0, 0, 0);
        rd_stat(v); chk("R5 status after empty read", v, 8'h03);
        rd_dat(v);  chk("R5 byte kept", v, 8'h5A);

        // R7 other addresses
        cyc(1, 8'h33, 3'b100, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, A_STAT); chk("R10 status load", rd_data, 8'h09);
        @(negedge clk); chk("R10 hold", rd_data, 8'h09);
        cyc(0, 0, 0, 0, 1, A_DATA - 16'h20); chk("R7 other channel", rd_data, 8'h00);
        cyc(0, 0, 0, 0, 1, A_DATA + 16'h1);  chk("R7 next address", rd_data, 8'h00);
        rd_stat(v); chk("R7 no pop", v, 8'h09);
        rd_dat(v);  chk("R7 data intact", v, 8'h33);

        // R9 simultaneous on empty
        cyc(1, 8'h44, 3'b000, 0, 1, A_DATA); chk("R9 empty read", rd_data, 8'h00);
        rd_stat(v); chk("R9 write kept", v, 8'h01);
        // R9 simultaneous on non-empty
        cyc(1, 8'h55, 3'b100, 0, 1, A_DATA); chk("R9 pop old", rd_data, 8'h44);
        rd_stat(v); chk("R9 new head", v, 8'h09);
        rd_dat(v);  chk("R9 new data", v, 8'h55);
        rd_stat(v); chk("R9 empty again", v, 8'h00);

        // R8 fill, overflow, drain
        do_reset();
        for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i), 3'b000, 0, 0, 0);
        chk("R8 no overflow at full", {7'b0, ovf}, 8'h00);
        cyc(1, 8'hEE, 3'b111, 0, 0, 0);
        chk("R8 overflow set", {7'b0, ovf}, 8'h01);
        for (int i = 0; i < DEPTH; i++) begin
            rd_dat(v);
            if (v !== 8'(i) || i == 0 || i == DEPTH - 1) chk("R8 drain order", v, 8'(i));
        end
        rd_stat(v); chk("R8 dropped write absent", v, 8'h00);
        chk("R8 overflow sticky", {7'b0, ovf}, 8'h01);

        // R9 simultaneous on full
        do_reset();
        for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i + 1), 3'b000, 0, 0, 0);
        cyc(1, 8'hAB, 3'b100, 0, 1, A_DATA); chk("R9 full pop", rd_data, 8'h01);
        chk("R9 full no overflow", {7'b0, ovf}, 8'h00);
        for (int i = 1; i < DEPTH; i++) rd_dat(v);
        rd_stat(v); chk("R9 full tail status", v, 8'h09);
        rd_dat(v);  chk("R9 full tail data", v, 8'hAB);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule